// File: doc/BRIEF.md
# Vectored Interrupt Receiver

This block sits between sixteen level-sensitive peripheral interrupt lines and a processor that takes one vectored interrupt at a time. Each clock it samples the lines. Only lines with an entry in a fixed, sparse line-to-vector table take part. When the receiver is idle and a mapped line is high, the receiver latches a three-word data record that carries the vector, marks itself busy, raises an interrupt request and sets the trap index to the vectored-interrupt trap. In the cycle the record is taken it also gives a one-cycle wake pulse to a halted core.

While busy, the receiver takes no further raises. The delivery ends in one of two ways: the line that caused it goes low, or the processor asserts its acknowledge input. When several mapped lines are high at once, the lowest line number is served first. The others stay pending for as long as their levels stay high, and they are looked at again once busy clears. An acknowledged line is ignored until it has gone low. This stops a line that is still held high from being delivered again and again.

Top module: `intvec_rx`

## Requirements
- R1: The fixed table maps line 1 to vector 0x29, line 4 to 0x2B, line 6 to 0x27, line 7 to 0x22 and line 12 to 0x2A. On delivery, `rec_w0_o` equals 0x7C0 OR vector (bits 10:6 all ones, bits 5:0 the vector, the upper bits zero). The values are 0x7E9, 0x7EB, 0x7E7, 0x7E2 and 0x7EA.
- R2: A line with no table entry never causes a delivery, whatever its level.
- R3: If a mapped line is high before clock edge n while the receiver is idle, `busy_o` and `irq_o` are high after edge n+1. `wake_o` is high for that single cycle only.
- R4: On every delivery `rec_w1_o` and `rec_w2_o` are zero.
- R5: While busy, a raise on any other line leaves `busy_o` and the record unchanged.
- R6: If the owning line is driven low before edge m, `busy_o`, `irq_o` and `trap_o` are clear after edge m+1.
- R7: `ack_i` held for one edge while busy clears busy after that edge. The acknowledged line is then ignored until it has been seen low. `ack_i` while idle has no effect.
- R8: When several mapped lines are high, the lowest line number is delivered first. The remaining lines are delivered, one at a time, after busy clears, with one idle cycle between deliveries.
- R9: `trap_o` equals 0x060 while busy and 0 otherwise.
- R10: After reset, `busy_o`, `irq_o`, `wake_o`, `trap_o` and all record words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lines_i | input | 16 | Peripheral interrupt levels |
| ack_i | input | 1 | Processor acknowledge; ends the current delivery |
| busy_o | output | 1 | A vector is being delivered |
| irq_o | output | 1 | Interrupt request to the processor |
| wake_o | output | 1 | One-cycle pulse that wakes a halted core |
| trap_o | output | 9 | Trap index, the vectored-interrupt trap while busy |
| rec_w0_o | output | 64 | Record word 0: tag and vector |
| rec_w1_o | output | 64 | Record word 1 (zero on delivery) |
| rec_w2_o | output | 64 | Record word 2 (zero on delivery) |

## Verification
The assertions assume that interrupt lines and `ack_i` change only between clock edges. They also assume a line keeps its level until the line has been sampled. The bench drives every input on the falling edge, so each level is held across at least one rising edge. The stimulus uses many overlapping raises of mapped and unmapped lines, a drop of the owning line, and an acknowledge that arrives while the owning line is still high. These cases cover the ownership and masking rules that the properties depend on.

// File: rtl/intvec_rx_pkg.sv
package intvec_rx_pkg;
  localparam int VEC_W = 6;
  localparam logic [4:0] REC_TAG = 5'h1F;

  typedef struct packed {
    logic             ok;
    logic [VEC_W-1:0] vec;
  } map_ent_t;

  function automatic map_ent_t line_map(input int idx);
    map_ent_t e;
    e = '0;
    case (idx)
      1:  e = '{ok: 1'b1, vec: 6'h29};
      4:  e = '{ok: 1'b1, vec: 6'h2B};
      6:  e = '{ok: 1'b1, vec: 6'h27};
      7:  e = '{ok: 1'b1, vec: 6'h22};
      12: e = '{ok: 1'b1, vec: 6'h2A};
      default: e = '0;
    endcase
    return e;
  endfunction
endpackage

// File: rtl/ivr_sample.sv
module ivr_sample #(
  parameter int N_LINES = 16
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] lines_i,
  output logic [N_LINES-1:0] src_q_o
);
  logic [N_LINES-1:0] src_d;

  always_comb src_d = lines_i;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) src_q_o <= '0;
    else         src_q_o <= src_d;
  end
endmodule

// File: rtl/ivr_pick.sv
module ivr_pick
  import intvec_rx_pkg::*;
#(
  parameter int N_LINES = 16,
  localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic [N_LINES-1:0] cand_i,
  output logic [N_LINES-1:0] mapped_o,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [VEC_W-1:0]   vec_o
);
  logic [VEC_W-1:0] vec_tab [N_LINES];

  for (genvar g = 0; g < N_LINES; g++) begin : g_map
    localparam map_ent_t ENT = line_map(g);
    assign mapped_o[g] = ENT.ok;
    assign vec_tab[g]  = ENT.vec;
  end

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    vec_o = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (cand_i[i] && mapped_o[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
        vec_o = vec_tab[i];
      end
    end
  end

  // R8: the chosen line is a mapped candidate, and no lower one is
  always_comb begin
    if (hit_o) begin
      a_r8_pick_lowest: assert (cand_i[idx_o] && mapped_o[idx_o] &&
        ((cand_i & mapped_o & ((N_LINES'(1) << idx_o) - N_LINES'(1))) == '0));
    end
  end
endmodule

// File: rtl/ivr_record.sv
module ivr_record
  import intvec_rx_pkg::*;
#(
  parameter int WORD_W = 64,
  localparam int PAD_W = WORD_W - VEC_W - 5
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic [WORD_W-1:0] w0_o,
  output logic [WORD_W-1:0] w1_o,
  output logic [WORD_W-1:0] w2_o
);
  logic [WORD_W-1:0] w0_d, w1_d, w2_d;

  always_comb begin
    w0_d = w0_o;
    w1_d = w1_o;
    w2_d = w2_o;
    if (load_i) begin
      w0_d = {{PAD_W{1'b0}}, REC_TAG, vec_i};
      w1_d = '0;
      w2_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      w0_o <= '0;
      w1_o <= '0;
      w2_o <= '0;
    end else begin
      w0_o <= w0_d;
      w1_o <= w1_d;
      w2_o <= w2_d;
    end
  end
endmodule

// File: rtl/intvec_rx.sv
module intvec_rx
  import intvec_rx_pkg::*;
#(
  parameter int N_LINES = 16,
  parameter int WORD_W = 64,
  parameter int TRAP_W = 9,
  parameter logic [TRAP_W-1:0] TRAP_VEC = 9'h060,
  localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] lines_i,
  input  logic               ack_i,
  output logic               busy_o,
  output logic               irq_o,
  output logic               wake_o,
  output logic [TRAP_W-1:0]  trap_o,
  output logic [WORD_W-1:0]  rec_w0_o,
  output logic [WORD_W-1:0]  rec_w1_o,
  output logic [WORD_W-1:0]  rec_w2_o
);
  // reset: asserted asynchronously, released after two edges
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  logic [N_LINES-1:0] src_q, mapped, mask_q, mask_d, cand;
  logic               hit;
  logic [IDX_W-1:0]   pick_idx, owner_q, owner_d;
  logic [VEC_W-1:0]   pick_vec;
  logic               busy_q, busy_d, wake_d, start, clr, owner_lvl;
  logic [TRAP_W-1:0]  trap_d;

  ivr_sample #(.N_LINES(N_LINES)) u_sample (
    .clk(clk), .rst_ni(rst_ni), .lines_i(lines_i), .src_q_o(src_q)
  );

  assign cand = src_q & ~mask_q;

  ivr_pick #(.N_LINES(N_LINES)) u_pick (
    .cand_i(cand), .mapped_o(mapped), .hit_o(hit), .idx_o(pick_idx), .vec_o(pick_vec)
  );

  assign owner_lvl = src_q[owner_q];

  always_comb begin
    start   = !busy_q && hit;
    clr     = busy_q && (ack_i || !owner_lvl);
    busy_d  = busy_q;
    owner_d = owner_q;
    trap_d  = trap_o;
    wake_d  = start;
    if (start) begin
      busy_d  = 1'b1;
      owner_d = pick_idx;
      trap_d  = TRAP_VEC;
    end else if (clr) begin
      busy_d = 1'b0;
      trap_d = '0;
    end
    for (int i = 0; i < N_LINES; i++) begin
      mask_d[i] = src_q[i] &&
                  (mask_q[i] || (ack_i && busy_q && (owner_q == IDX_W'(i))));
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
      mask_q  <= '0;
      wake_o  <= 1'b0;
      trap_o  <= '0;
    end else begin
      busy_q  <= busy_d;
      owner_q <= owner_d;
      mask_q  <= mask_d;
      wake_o  <= wake_d;
      trap_o  <= trap_d;
    end
  end

  assign busy_o = busy_q;
  assign irq_o  = busy_q;

  ivr_record #(.WORD_W(WORD_W)) u_rec (
    .clk(clk), .rst_ni(rst_ni), .load_i(start), .vec_i(pick_vec),
    .w0_o(rec_w0_o), .w1_o(rec_w1_o), .w2_o(rec_w2_o)
  );

  // R3: the wake pulse comes together with busy and lasts one cycle
  a_r3_wake_single: assert property (@(posedge clk) disable iff (!rst_ni)
    wake_o |-> busy_o ##1 !wake_o);

  // R4 and R1: record layout while busy
  a_r4_record_form: assert property (@(posedge clk) disable iff (!rst_ni)
    busy_o |-> (rec_w0_o[10:6] == 5'h1F && rec_w1_o == '0 && rec_w2_o == '0));

  // R1: only table vectors are delivered
  a_r1_vec_in_table: assert property (@(posedge clk) disable iff (!rst_ni)
    busy_o |-> (rec_w0_o[5:0] inside {6'h29, 6'h2B, 6'h27, 6'h22, 6'h2A}));

  // R5: a delivery stays put while its line is high and there is no ack
  a_r5_hold_busy: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_o && owner_lvl && !ack_i) |=> (busy_o && $stable(rec_w0_o)));

  // R6: a drop of the owning line ends the delivery
  a_r6_drop_clears: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_o && !owner_lvl) |=> (!busy_o && !irq_o));

  // R7: an ack ends the delivery
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_o && ack_i) |=> !busy_o);

  // R9: trap index follows busy
  a_r9_trap_busy: assert property (@(posedge clk) disable iff (!rst_ni)
    (trap_o == TRAP_VEC) == busy_o);
endmodule

// File: tb/intvec_rx_bench.sv
module intvec_rx_bench;
  logic        clk;
  logic        rst_n;
  logic [15:0] lines;
  logic        ack;
  logic        busy, irq, wake;
  logic [8:0]  trap;
  logic [63:0] w0, w1, w2;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit model_on = 0;

  intvec_rx u_intvec_rx (
    .clk(clk), .rst_n(rst_n), .lines_i(lines), .ack_i(ack),
    .busy_o(busy), .irq_o(irq), .wake_o(wake), .trap_o(trap),
    .rec_w0_o(w0), .rec_w1_o(w1), .rec_w2_o(w2)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // reference model
  function automatic int vec_of(input int ln);
    case (ln)
      1: return 'h29;  4: return 'h2B;  6: return 'h27;
      7: return 'h22;  12: return 'h2A;
      default: return -1;
    endcase
  endfunction

  bit   m_seen [16];
  bit   m_held [16];
  bit   m_busy, m_wake;
  int   m_line;
  longint m_w0;

  always @(posedge clk) begin
    if (!model_on) begin
      foreach (m_seen[i]) begin m_seen[i] = 0; m_held[i] = 0; end
      m_busy = 0; m_wake = 0; m_line = 0; m_w0 = 0;
    end else begin
      int sel;
      bit nb, nw;
      int nl;
      longint nw0;
      bit nheld [16];
      sel = -1;
      for (int i = 15; i >= 0; i--)
        if (m_seen[i] && !m_held[i] && vec_of(i) >= 0) sel = i;
      nb = m_busy; nw = 0; nl = m_line; nw0 = m_w0;
      if (!m_busy && sel >= 0) begin
        nb = 1; nw = 1; nl = sel; nw0 = 'h7C0 | vec_of(sel);
      end else if (m_busy && (ack || !m_seen[m_line])) begin
        nb = 0;
      end
      for (int i = 0; i < 16; i++)
        nheld[i] = m_seen[i] && (m_held[i] || (ack && m_busy && m_line == i));
      m_busy = nb; m_wake = nw; m_line = nl; m_w0 = nw0;
      for (int i = 0; i < 16; i++) begin
        m_held[i] = nheld[i];
        m_seen[i] = lines[i];
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (model_on) begin
      chk("R3 busy", busy, m_busy);
      chk("R3 irq", irq, m_busy);
      chk("R3 wake", wake, m_wake);
      chk("R9 trap", trap, m_busy ? 'h60 : 0);
      chk("R1 word0", w0, m_w0);
      chk("R4 word1", w1, 0);
      chk("R4 word2", w2, 0);
    end
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<5000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; lines = '0; ack = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);
    // R10 reset state
    chk("R10 busy", busy, 0); chk("R10 wake", wake, 0);
    chk("R10 trap", trap, 0); chk("R10 word0", w0, 0);
    model_on = 1;
    // R1/R3: line 1 delivered two edges after raise
    lines[1] = 1'b1;
    step(1); chk("R3 not yet busy", busy, 0);
    step(1); chk("R3 busy", busy, 1); chk("R3 wake", wake, 1);
    chk("R1 line1", w0, 'h7E9); chk("R9 trap", trap, 'h60);
    // R5: raise line 4 while busy
    lines[4] = 1'b1;
    step(3); chk("R5 still line1", w0, 'h7E9); chk("R5 busy", busy, 1);
    // R6: drop owner, then R8 pending line 4 delivered
    lines[1] = 1'b0;
    step(2); chk("R6 cleared", busy, 0); chk("R6 trap", trap, 0);
    step(1); chk("R8 pending line4", w0, 'h7EB); chk("R8 busy", busy, 1);
    // R7: ack while line 4 held high
    ack = 1'b1; step(1); ack = 1'b0;
    chk("R7 ack clears", busy, 0);
    step(4); chk("R7 held line masked", busy, 0);
    lines[4] = 1'b0; step(3);
    ack = 1'b1; step(2); ack = 1'b0;
    chk("R7 idle ack no effect", busy, 0);
    // R2: unmapped lines
    lines = 16'h802D & ~16'h0012; // lines 0,2,3,5,15
    step(5); chk("R2 unmapped ignored", busy, 0);
    lines = '0; step(2);
    // R8: lines 6,7,12 together
    lines = 16'h10C0;
    step(2); chk("R8 lowest first", w0, 'h7E7);
    lines[6] = 1'b0;
    step(3); chk("R8 next line7", w0, 'h7E2);
    lines[7] = 1'b0;
    step(3); chk("R8 last line12", w0, 'h7EA);
    lines = '0; step(3);
    // R4 after re-delivery of line 4
    lines[4] = 1'b1; step(2);
    chk("R4 w1", w1, 0); chk("R4 w2", w2, 0); chk("R1 line4", w0, 'h7EB);
    lines = '0; step(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule